// File: doc/BRIEF.md
# Parallel Camera Bus Capture Receiver

This block sits behind a parallel camera port. It watches a pixel clock, frame and line sync lines, a data-enable line and a data bus of up to 16 bits. It turns qualified pixel samples into 16-bit words on a valid/ready stream that feeds a receive FIFO. The block samples the camera lines in the system clock domain and detects the active edge of the pixel clock there, so the camera clock must run well below the system clock.

Configuration fields are presented on ports and copied into the active set only on an update strobe. The fields cover:
- bus width,
- framing rule,
- frame-sync glitch filter,
- byte swap and bit reversal,
- per-line polarity,
- the end-of-transfer rule,
- halting on backpressure.

Software pulses the control reset and the FIFO reset, then sets the start bit. It can poll `running` to learn that the block has halted itself.

Top module: `cam_capture`

## Requirements
- R1: After reset `outValid` and `running` are both 0.
- R2: Samples are taken only while `running` is 1. `startSet` raises it and `startClr` lowers it. Bus activity while it is 0 puts no word on the output.
- R3: A change on a configuration port has no effect until `cfgUpdate` is pulsed. The active values apply to samples after that pulse.
- R4: In 8-bit mode (`cfgWide`=0) two samples of `camData[7:0]` form one word. The first sample goes to bits 7:0. With `cfgByteSwap`=1 the first sample goes to bits 15:8.
- R5: In 16-bit mode each sample yields one word from `camData[15:0]`. `cfgByteSwap`=1 exchanges its two bytes.
- R6: `cfgBitRev`=1 reverses the bit order of each sample: within the byte in 8-bit mode and within the word in 16-bit mode. The reversal is applied before any byte swap.
- R7: A sample is taken on an active pixel-clock edge only inside a frame. With `cfgDeOnly`=0 the frame sync, line sync and data enable must all be active. With `cfgDeOnly`=1 the line sync is ignored.
- R8: Each of pixel clock, data enable, line sync and frame sync has its own inversion bit. The active pixel edge is the rising edge after inversion, and each sync or enable line is active high after inversion.
- R9: With `cfgFiltEn`=1 and threshold T (0..7), data is accepted only from the (T+1)-th consecutive active edge that sees frame sync active. Any edge that sees it inactive restarts the count.
- R10: With `cfgEofByLen`=1 a byte count runs; 16-bit samples count 2 bytes. The word that brings the count to `cfgLen` carries `outLast`=1, and the count restarts from 0. In 8-bit mode a lone byte that reaches the count is sent at once, in its first-byte position, with the other byte 0.
- R11: With `cfgEofByLen`=0 each completed word is held until the next word completes. When frame sync goes inactive the held word is sent with `outLast`=1 and an unpaired byte is discarded.
- R12: While `outValid`=1 and `outReady`=0 the output word is held. A word completed in that state is dropped. If `cfgStopEn`=1, `running` also falls.
- R13: `fifoReset` empties the output, the held word, the partial byte and the byte count. `ctlReset` does the same and also clears `running` and the frame tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| camPclk | input | 1 | Camera pixel clock |
| camVsync | input | 1 | Frame sync |
| camHsync | input | 1 | Line sync |
| camDe | input | 1 | Data enable |
| camData | input | DW | Camera data bus |
| cfgWide | input | 1 | 1: 16-bit bus, 0: 8-bit bus |
| cfgDeOnly | input | 1 | 1: ignore line sync |
| cfgFiltEn | input | 1 | Frame-sync filter enable |
| cfgFiltThr | input | 3 | Filter threshold T (T+1 edges) |
| cfgByteSwap | input | 1 | Swap word bytes |
| cfgBitRev | input | 1 | Reverse sample bits |
| cfgPclkInv | input | 1 | Invert pixel clock |
| cfgDeInv | input | 1 | Invert data enable |
| cfgHsInv | input | 1 | Invert line sync |
| cfgVsInv | input | 1 | Invert frame sync |
| cfgEofByLen | input | 1 | 1: end by byte count, 0: end by frame sync |
| cfgStopEn | input | 1 | Halt on backpressure |
| cfgLen | input | LW | Bytes per transfer |
| cfgUpdate | input | 1 | Copy configuration ports into the active set |
| ctlReset | input | 1 | Control reset pulse |
| fifoReset | input | 1 | Output path reset pulse |
| startSet | input | 1 | Set the start bit |
| startClr | input | 1 | Clear the start bit |
| running | output | 1 | Start bit; falls on self-stop |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Consumer ready |
| outData | output | DW | Output word |
| outLast | output | 1 | End-of-transfer marker |

## Verification
Errors in the frame tracking or the filter count change the set of accepted samples. They show up in the first output word after the faulty edge as the wrong byte pairing. A byte count that is off shows up as `outLast` on the wrong word within one transfer. A held word that is not released shows up when frame sync falls, as a missing marked word. A broken stop path shows up one cycle after a stalled overflow, as `running` staying high.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;
  typedef struct packed {
    logic       wide;
    logic       deOnly;
    logic       filtEn;
    logic [2:0] filtThr;
    logic       byteSwap;
    logic       bitRev;
    logic       pclkInv;
    logic       deInv;
    logic       hsInv;
    logic       vsInv;
    logic       eofByLen;
    logic       stopEn;
  } cap_cfg_t;

  typedef struct packed {
    logic sample;    // take a data sample this cycle
    logic frameEnd;  // frame sync went inactive
    logic flush;     // clear output path
  } cap_stb_t;
endpackage

// File: rtl/cam_cap_ctrl.sv
module cam_cap_ctrl
  import cam_cap_pkg::*;
#(
  parameter int DW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          camPclk,
  input  logic          camVsync,
  input  logic          camHsync,
  input  logic          camDe,
  input  logic [DW-1:0] camData,
  input  cap_cfg_t      cfgIn,
  input  logic [LW-1:0] lenIn,
  input  logic          cfgUpdate,
  input  logic          ctlReset,
  input  logic          fifoReset,
  input  logic          startSet,
  input  logic          startClr,
  input  logic          overflow,
  output cap_cfg_t      cfgAct,
  output logic [LW-1:0] lenAct,
  output cap_stb_t      stb,
  output logic [DW-1:0] sampData,
  output logic          running
);
  localparam int CW = 3;
  localparam logic [CW-1:0] CMAX = '1;

  logic pS, vS, hS, dS, pPrev;
  logic [DW-1:0] dataS;
  logic [CW-1:0] vsCnt;
  logic frameAct;
  logic pEff, vEff, hEff, dEff, edgeP, live, frameNow, qual;
  logic [CW-1:0] thr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgAct <= '0;
      lenAct <= '0;
    end else if (cfgUpdate) begin
      cfgAct <= cfgIn;
      lenAct <= lenIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {pS, vS, hS, dS, pPrev} <= '0;
      dataS <= '0;
    end else begin
      pS    <= camPclk;
      vS    <= camVsync;
      hS    <= camHsync;
      dS    <= camDe;
      dataS <= camData;
      pPrev <= pEff;
    end
  end

  always_comb begin
    pEff     = pS ^ cfgAct.pclkInv;
    vEff     = vS ^ cfgAct.vsInv;
    hEff     = hS ^ cfgAct.hsInv;
    dEff     = dS ^ cfgAct.deInv;
    edgeP    = pEff & ~pPrev;
    live     = running & edgeP;
    thr      = cfgAct.filtEn ? cfgAct.filtThr : '0;
    frameNow = vEff & (vsCnt >= thr);
    qual     = cfgAct.deOnly ? dEff : (dEff & hEff);
    stb.sample   = live & frameNow & qual;
    stb.frameEnd = live & frameAct & ~vEff;
    stb.flush    = ctlReset | fifoReset;
    sampData     = dataS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vsCnt    <= '0;
      frameAct <= 1'b0;
    end else if (ctlReset) begin
      vsCnt    <= '0;
      frameAct <= 1'b0;
    end else if (live) begin
      vsCnt    <= !vEff ? '0 : (vsCnt == CMAX ? CMAX : vsCnt + 1'b1);
      frameAct <= frameNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) running <= 1'b0;
    else if (ctlReset || startClr) running <= 1'b0;
    else if (overflow && cfgAct.stopEn) running <= 1'b0;
    else if (startSet) running <= 1'b1;
  end
endmodule

// File: rtl/cam_cap_dpath.sv
module cam_cap_dpath
  import cam_cap_pkg::*;
#(
  parameter int DW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  cap_cfg_t      cfg,
  input  logic [LW-1:0] len,
  input  cap_stb_t      stb,
  input  logic [DW-1:0] sampData,
  input  logic          outReady,
  output logic          outValid,
  output logic [DW-1:0] outData,
  output logic          outLast,
  output logic          overflow
);
  localparam int HW = DW / 2;

  logic          halfV, pendV;
  logic [HW-1:0] halfD;
  logic [DW-1:0] pendD;
  logic [LW-1:0] byteCnt;
  logic [HW-1:0] byteIn;
  logic [DW-1:0] wordIn, word;
  logic [LW:0]   nextCnt;
  logic          lenHit, wordRdy, push, pushLast, canTake;
  logic [DW-1:0] pushData;

  always_comb begin
    for (int i = 0; i < HW; i++)
      byteIn[i] = cfg.bitRev ? sampData[HW-1-i] : sampData[i];
    for (int i = 0; i < DW; i++)
      wordIn[i] = cfg.bitRev ? sampData[DW-1-i] : sampData[i];
  end

  always_comb begin
    nextCnt = {1'b0, byteCnt} + (cfg.wide ? (LW+1)'(2) : (LW+1)'(1));
    lenHit  = cfg.eofByLen && (nextCnt >= {1'b0, len});
    wordRdy = 1'b0;
    word    = '0;
    if (cfg.wide) begin
      wordRdy = 1'b1;
      word    = cfg.byteSwap ? {wordIn[HW-1:0], wordIn[DW-1:HW]} : wordIn;
    end else if (halfV) begin
      wordRdy = 1'b1;
      word    = cfg.byteSwap ? {halfD, byteIn} : {byteIn, halfD};
    end else if (lenHit) begin
      wordRdy = 1'b1;
      word    = cfg.byteSwap ? {byteIn, {HW{1'b0}}} : {{HW{1'b0}}, byteIn};
    end
  end

  always_comb begin
    push     = 1'b0;
    pushData = word;
    pushLast = 1'b0;
    if (cfg.eofByLen) begin
      push     = stb.sample & wordRdy;
      pushLast = lenHit;
    end else begin
      pushData = pendD;
      if (stb.sample && wordRdy && pendV) push = 1'b1;
      if (stb.frameEnd && pendV) begin
        push     = 1'b1;
        pushLast = 1'b1;
      end
    end
    canTake  = !outValid || outReady;
    overflow = push && !canTake;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {halfV, pendV, outValid, outLast} <= '0;
      halfD   <= '0;
      pendD   <= '0;
      outData <= '0;
      byteCnt <= '0;
    end else if (stb.flush) begin
      {halfV, pendV, outValid, outLast} <= '0;
      byteCnt <= '0;
    end else begin
      if (outValid && outReady) outValid <= 1'b0;
      if (push && canTake) begin
        outValid <= 1'b1;
        outData  <= pushData;
        outLast  <= pushLast;
      end
      if (stb.sample) begin
        if (!cfg.wide) begin
          halfV <= !wordRdy;
          if (!wordRdy) halfD <= byteIn;
        end
        if (cfg.eofByLen) byteCnt <= lenHit ? '0 : nextCnt[LW-1:0];
        if (!cfg.eofByLen && wordRdy) begin
          pendV <= 1'b1;
          pendD <= word;
        end
      end
      if (stb.frameEnd) begin
        halfV <= 1'b0;
        pendV <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cam_capture.sv
module cam_capture
  import cam_cap_pkg::*;
#(
  parameter int DW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          camPclk,
  input  logic          camVsync,
  input  logic          camHsync,
  input  logic          camDe,
  input  logic [DW-1:0] camData,
  input  logic          cfgWide,
  input  logic          cfgDeOnly,
  input  logic          cfgFiltEn,
  input  logic [2:0]    cfgFiltThr,
  input  logic          cfgByteSwap,
  input  logic          cfgBitRev,
  input  logic          cfgPclkInv,
  input  logic          cfgDeInv,
  input  logic          cfgHsInv,
  input  logic          cfgVsInv,
  input  logic          cfgEofByLen,
  input  logic          cfgStopEn,
  input  logic [LW-1:0] cfgLen,
  input  logic          cfgUpdate,
  input  logic          ctlReset,
  input  logic          fifoReset,
  input  logic          startSet,
  input  logic          startClr,
  output logic          running,
  output logic          outValid,
  input  logic          outReady,
  output logic [DW-1:0] outData,
  output logic          outLast
);
  cap_cfg_t      cfgIn, cfgAct;
  cap_stb_t      stb;
  logic [LW-1:0] lenAct;
  logic [DW-1:0] sampData;
  logic          dpOverflow;

  always_comb begin
    cfgIn.wide     = cfgWide;
    cfgIn.deOnly   = cfgDeOnly;
    cfgIn.filtEn   = cfgFiltEn;
    cfgIn.filtThr  = cfgFiltThr;
    cfgIn.byteSwap = cfgByteSwap;
    cfgIn.bitRev   = cfgBitRev;
    cfgIn.pclkInv  = cfgPclkInv;
    cfgIn.deInv    = cfgDeInv;
    cfgIn.hsInv    = cfgHsInv;
    cfgIn.vsInv    = cfgVsInv;
    cfgIn.eofByLen = cfgEofByLen;
    cfgIn.stopEn   = cfgStopEn;
  end

  cam_cap_ctrl #(.DW(DW), .LW(LW)) uCtrl (
    .clk(clk), .rstN(rstN),
    .camPclk(camPclk), .camVsync(camVsync), .camHsync(camHsync), .camDe(camDe),
    .camData(camData), .cfgIn(cfgIn), .lenIn(cfgLen), .cfgUpdate(cfgUpdate),
    .ctlReset(ctlReset), .fifoReset(fifoReset), .startSet(startSet), .startClr(startClr),
    .overflow(dpOverflow), .cfgAct(cfgAct), .lenAct(lenAct), .stb(stb),
    .sampData(sampData), .running(running)
  );

  cam_cap_dpath #(.DW(DW), .LW(LW)) uDpath (
    .clk(clk), .rstN(rstN), .cfg(cfgAct), .len(lenAct), .stb(stb),
    .sampData(sampData), .outReady(outReady), .outValid(outValid),
    .outData(outData), .outLast(outLast), .overflow(dpOverflow)
  );
endmodule

// File: rtl/cam_cap_checker.sv
module cam_cap_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          ctlReset,
  input logic          fifoReset,
  input logic          startSet,
  input logic          outReady,
  input logic          outValid,
  input logic [DW-1:0] outData,
  input logic          outLast,
  input logic          running,
  input logic          overflow,
  input logic          stopEn
);
  // R12: a stalled word stays put
  a_r12_hold_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !ctlReset && !fifoReset)
      |=> (outValid && $stable(outData) && $stable(outLast)));

  // R12: overflow with stop enabled halts capture
  a_r12_self_stop: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && stopEn && !ctlReset) |=> !running);

  // R13: either reset empties the output
  a_r13_flush_empty: assert property (@(posedge clk) disable iff (!rstN)
    (fifoReset || ctlReset) |=> !outValid);

  // R2: nothing new appears while stopped
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !outValid && !startSet) |=> !outValid);
endmodule

bind cam_capture cam_cap_checker #(.DW(DW)) uChk (
  .clk(clk), .rstN(rstN), .ctlReset(ctlReset), .fifoReset(fifoReset),
  .startSet(startSet), .outReady(outReady), .outValid(outValid),
  .outData(outData), .outLast(outLast), .running(running),
  .overflow(dpOverflow), .stopEn(cfgAct.stopEn)
);

// File: tb/tb_cam_capture.sv
module tb_cam_capture;
  localparam int DW = 16;
  localparam int LW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic camPclk = 0, camVsync = 0, camHsync = 0, camDe = 0;
  logic [DW-1:0] camData = '0;
  logic cfgWide = 0, cfgDeOnly = 0, cfgFiltEn = 0, cfgByteSwap = 0, cfgBitRev = 0;
  logic [2:0] cfgFiltThr = '0;
  logic cfgPclkInv = 0, cfgDeInv = 0, cfgHsInv = 0, cfgVsInv = 0;
  logic cfgEofByLen = 0, cfgStopEn = 0;
  logic [LW-1:0] cfgLen = '0;
  logic cfgUpdate = 0, ctlReset = 0, fifoReset = 0, startSet = 0, startClr = 0;
  logic outReady = 1'b1;
  logic running, outValid, outLast;
  logic [DW-1:0] outData;

  int checks = 0;
  int fails = 0;
  logic [16:0] expQ[$];
  string expTag[$];

  always #4 clk = ~clk;

  cam_capture #(.DW(DW), .LW(LW)) dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishUp();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Monitor: pop and compare each accepted word
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      if (expQ.size() == 0) check("unexpected word", {15'd0, outLast, outData}, 32'hFFFF_FFFF);
      else begin
        automatic logic [16:0] e = expQ.pop_front();
        automatic string t = expTag.pop_front();
        check(t, {15'd0, outLast, outData}, {15'd0, e});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finishUp();
  end

  task automatic expect_w(input string t, input logic last, input logic [15:0] w);
    expQ.push_back({last, w});
    expTag.push_back(t);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic pix(input logic v, input logic h, input logic d, input logic [15:0] x);
    @(negedge clk);
    camVsync = v ^ cfgVsInv; camHsync = h ^ cfgHsInv; camDe = d ^ cfgDeInv;
    camData = x; camPclk = cfgPclkInv;
    repeat (2) @(negedge clk);
    camPclk = ~cfgPclkInv;
    repeat (2) @(negedge clk);
  endtask

  task automatic setup(input logic wide, input logic deOnly, input logic eofLen,
                       input logic [LW-1:0] len);
    @(negedge clk);
    cfgWide = wide; cfgDeOnly = deOnly; cfgEofByLen = eofLen; cfgLen = len;
    camPclk = cfgPclkInv;
    pulse(cfgUpdate);
    repeat (3) @(negedge clk);
    pulse(ctlReset);
    pulse(fifoReset);
    pulse(startSet);
  endtask

  task automatic drain(input string t);
    repeat (6) @(negedge clk);
    check(t, expQ.size(), 0);
  endtask

  function automatic logic [15:0] rev16(input logic [15:0] v);
    for (int i = 0; i < 16; i++) rev16[i] = v[15-i];
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1 outValid after reset", outValid, 0);
    check("R1 running after reset", running, 0);
    rstN = 1'b1;

    // R4 / R7 / R10: 8-bit, DE-only (line sync held low), length 4
    setup(0, 1, 1, 4);
    check("R2 running after start", running, 1);
    expect_w("R4 pair low-first", 0, 16'hB2A1);
    expect_w("R10 last on count", 1, 16'hD4C3);
    pix(1, 0, 1, 16'h00A1); pix(1, 0, 1, 16'h00B2);
    pix(1, 0, 1, 16'h00C3); pix(1, 0, 1, 16'h00D4);
    drain("R7 DE-only ignores line sync");

    // R3: swap field changed without update has no effect
    @(negedge clk); cfgByteSwap = 1'b1;
    expect_w("R3 swap not yet active", 0, 16'h2211);
    pix(1, 0, 1, 16'h0011); pix(1, 0, 1, 16'h0022);
    pulse(cfgUpdate);
    expect_w("R3/R4 swap after update", 1, 16'h3344);
    pix(1, 0, 1, 16'h0033); pix(1, 0, 1, 16'h0044);
    drain("R3 queue");
    cfgByteSwap = 1'b0;

    // R5 / R6: 16-bit with bit reversal, then swap
    cfgBitRev = 1'b1;
    setup(1, 1, 1, 4);
    expect_w("R6 word reversed", 0, rev16(16'h0001));
    expect_w("R5/R6 reversed word last", 1, rev16(16'h1234));
    pix(1, 0, 1, 16'h0001); pix(1, 0, 1, 16'h1234);
    drain("R6 queue");
    cfgBitRev = 1'b0; cfgByteSwap = 1'b1;
    setup(1, 1, 1, 2);
    expect_w("R5 16-bit swap", 1, 16'hCDAB);
    pix(1, 0, 1, 16'hABCD);
    drain("R5 queue");
    cfgByteSwap = 1'b0;

    // R6: 8-bit reversal within a byte
    cfgBitRev = 1'b1;
    setup(0, 1, 1, 2);
    expect_w("R6 byte reversed", 1, 16'h4080);
    pix(1, 0, 1, 16'h0001); pix(1, 0, 1, 16'h0002);
    drain("R6 byte queue");
    cfgBitRev = 1'b0;

    // R7: sync mode needs line sync and enable
    setup(0, 0, 1, 2);
    expect_w("R7 sync qualification", 1, 16'h0201);
    pix(1, 0, 1, 16'h00EE); pix(1, 1, 1, 16'h0001);
    pix(1, 1, 0, 16'h00FF); pix(1, 1, 1, 16'h0002);
    drain("R7 queue");

    // R8: all lines inverted
    cfgPclkInv = 1; cfgDeInv = 1; cfgHsInv = 1; cfgVsInv = 1;
    setup(0, 0, 1, 2);
    expect_w("R8 inverted lines", 1, 16'hA55A);
    pix(1, 1, 1, 16'h005A); pix(1, 1, 0, 16'h0077); pix(1, 1, 1, 16'h00A5);
    drain("R8 queue");
    cfgPclkInv = 0; cfgDeInv = 0; cfgHsInv = 0; cfgVsInv = 0;

    // R9: filter threshold 2 -> third consecutive active edge
    cfgFiltEn = 1; cfgFiltThr = 3'd2;
    setup(0, 1, 1, 2);
    expect_w("R9 filter", 1, 16'h0403);
    pix(1, 0, 1, 16'h0009); pix(0, 0, 1, 16'h0008);
    pix(1, 0, 1, 16'h0001); pix(1, 0, 1, 16'h0002);
    pix(1, 0, 1, 16'h0003); pix(1, 0, 1, 16'h0004);
    drain("R9 queue");
    cfgFiltEn = 0; cfgFiltThr = '0;

    // R10: odd length, lone final byte
    setup(0, 1, 1, 3);
    expect_w("R10 pair", 0, 16'h6261);
    expect_w("R10 lone byte", 1, 16'h0063);
    pix(1, 0, 1, 16'h0061); pix(1, 0, 1, 16'h0062); pix(1, 0, 1, 16'h0063);
    drain("R10 queue");

    // R11: end by frame sync
    setup(0, 1, 0, 0);
    expect_w("R11 held word", 0, 16'h2010);
    expect_w("R11 last at frame end", 1, 16'h4030);
    pix(1, 0, 1, 16'h0010); pix(1, 0, 1, 16'h0020); pix(1, 0, 1, 16'h0030);
    pix(1, 0, 1, 16'h0040); pix(1, 0, 1, 16'h0050);
    pix(0, 0, 0, 16'h0000);
    drain("R11 queue");

    // R12: stall with stop enabled
    cfgStopEn = 1;
    setup(0, 1, 1, 100);
    outReady = 0;
    pix(1, 0, 1, 16'h0001); pix(1, 0, 1, 16'h0002);
    pix(1, 0, 1, 16'h0003); pix(1, 0, 1, 16'h0004);
    check("R12 self stop", running, 0);
    check("R12 held valid", outValid, 1);
    check("R12 held data", outData, 16'h0201);
    pix(1, 0, 1, 16'h0005); pix(1, 0, 1, 16'h0006);
    check("R2 stopped ignores bus", outData, 16'h0201);
    expect_w("R12 held word delivered", 0, 16'h0201);
    @(negedge clk); outReady = 1;
    drain("R12 queue");
    check("R2 no word after stop", outValid, 0);
    cfgStopEn = 0;

    // R2: start cleared
    setup(0, 1, 1, 2);
    pulse(startClr);
    check("R2 startClr", running, 0);
    pix(1, 0, 1, 16'h0031); pix(1, 0, 1, 16'h0032);
    check("R2 no output when cleared", outValid, 0);

    // R13: FIFO reset drops partial byte, control reset stops
    setup(0, 1, 1, 2);
    pix(1, 0, 1, 16'h0077);
    pulse(fifoReset);
    expect_w("R13 partial dropped", 1, 16'h9988);
    pix(1, 0, 1, 16'h0088); pix(1, 0, 1, 16'h0099);
    drain("R13 queue");
    pulse(ctlReset);
    check("R13 ctlReset stops", running, 0);

    finishUp();
  end
endmodule